// File: doc/BRIEF.md
# Interrupt Status, Mask and Enable Unit

This unit gathers one-cycle event pulses from the transmit path, the receive path and the system bus logic of a network controller. It holds them in a sticky interrupt status register. Software reads that register to learn which events happened, and the read itself empties it. A per-bit mask register and a one-bit global enable decide whether the pending events raise the single level-sensitive interrupt line.

The upper group of status bits reports reset completion and bus or FIFO faults. These bits are also folded into one summary bit, so a handler can test one bit to see whether any of them is pending. Status bits latch whether or not they are masked, so a polling driver still sees masked events. An event that arrives in the same cycle as a status read is not lost: it waits for the next read.

Register access uses a plain strobe interface with a two-bit word address, a write strobe, a read strobe and combinational read data. No data streams through the block, so none of its pins uses a valid/ready handshake.

Top module: `isu_top`

## Requirements
- R1: After reset the status, mask and enable registers are all zero and `irq_o` is low.
- R2: An event pulse on an implemented status bit sets that bit one cycle later, and the bit stays set until a status read. The implemented bits are 0 to 14, 16 and 20 to 25.
- R3: A read strobe at address 0 returns the latched status in the same cycle, and from the next cycle the read bits are zero.
- R4: An event that coincides with a status read is absent from that read's data and present in the next status read.
- R5: Status read data bit 15 is the OR of status bits 25 down to 16.
- R6: Status bits latch whatever the mask register holds.
- R7: `irq_o` equals enable bit 0 AND the OR over (status read view AND mask). The status read view includes summary bit 15, so mask bit 15 gates the summary.
- R8: Event inputs at positions 15, 17, 18 and 19 are ignored. Those status positions, and data bits 26 to 31, read as zero.
- R9: A write to address 0 leaves the status unchanged.
- R10: Address 1 holds the 26-bit mask, read back with bits 26 to 31 zero.
- R11: Address 2 holds the enable in bit 0, read back with the other bits zero.
- R12: Reads from address 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 26 | One-cycle event pulses, one per status position |
| reg_addr_i | input | 2 | Register word address: 0 status, 1 mask, 2 enable |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rd_i | input | 1 | Read strobe; at address 0 it clears the status |
| reg_rdata_o | output | 32 | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
Two functions can fall in the same cycle: setting a status bit from a fresh event pulse, and clearing the status register on a read. The bench provokes this by pre-loading one bit, then raising an event on a different bit in the very cycle the read strobe is high. It judges the result by two things: the read returns only the pre-loaded bit, and the following read returns only the coincident bit. The bench also sweeps every event position, with the mask both open and shut, and compares the read data, the summary bit and the interrupt line with values it derives from the list of implemented bits.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int STAT_W  = 26;
  localparam int SUM_BIT = 15;
  localparam int HI_LO   = 16;
  localparam int HI_HI   = 25;
  localparam int ADDR_W  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT = 2'd0,
    A_MASK = 2'd1,
    A_EN   = 2'd2,
    A_NONE = 2'd3
  } isu_addr_e;

  function automatic logic [STAT_W-1:0] impl_bits();
    logic [STAT_W-1:0] m;
    for (int i = 0; i < STAT_W; i++)
      m[i] = (i < SUM_BIT) || (i == HI_LO) || (i >= 20 && i <= HI_HI);
    return m;
  endfunction

  localparam logic [STAT_W-1:0] IMPL = impl_bits();
endpackage

// File: rtl/isu_status_latch.sv
module isu_status_latch #(
  parameter int W = 26,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic         clr_i,
  output logic [W-1:0] stat_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (KEEP[i]) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_o[i] <= 1'b0;
        else        stat_o[i] <= (stat_o[i] & ~clr_i) | evt_i[i];
      end
    end else begin : g_zero
      assign stat_o[i] = 1'b0;
    end
  end

  logic unused_evt;
  assign unused_evt = ^(evt_i & ~KEEP);

  // R2
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_i & KEEP) != '0) |=> ((stat_o & $past(evt_i & KEEP)) == $past(evt_i & KEEP)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

  // R3
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> ((stat_o & ~$past(evt_i)) == '0));
endmodule

// File: rtl/isu_ctrl_regs.sv
module isu_ctrl_regs #(
  parameter int W = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we_i,
  input  logic         en_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o,
  output logic         en_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      en_o   <= 1'b0;
    end else begin
      if (mask_we_i) mask_o <= wdata_i;
      if (en_we_i)   en_o   <= wdata_i[0];
    end
  end
endmodule

// File: rtl/isu_irq_out.sv
module isu_irq_out #(
  parameter int W = 26
) (
  input  logic [W-1:0] view_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic         irq_o
);
  always_comb irq_o = en_i & (|(view_i & mask_i));
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  input  logic              reg_rd_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - STAT_W;

  logic [STAT_W-1:0] stat, view, mask;
  logic              en, clr, sum;
  isu_addr_e         addr;

  assign addr = isu_addr_e'(reg_addr_i);
  assign clr  = reg_rd_i && (addr == A_STAT);

  isu_status_latch #(.W(STAT_W), .KEEP(IMPL)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .clr_i(clr), .stat_o(stat)
  );

  isu_ctrl_regs #(.W(STAT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mask_we_i(reg_wr_i && (addr == A_MASK)),
    .en_we_i(reg_wr_i && (addr == A_EN)),
    .wdata_i(reg_wdata_i[STAT_W-1:0]),
    .mask_o(mask), .en_o(en)
  );

  always_comb begin
    sum  = |stat[HI_HI:HI_LO];
    view = stat;
    view[SUM_BIT] = sum;
  end

  isu_irq_out #(.W(STAT_W)) u_irq (
    .view_i(view), .mask_i(mask), .en_i(en), .irq_o(irq_o)
  );

  always_comb begin
    case (addr)
      A_STAT:  reg_rdata_o = {{PAD_W{1'b0}}, view};
      A_MASK:  reg_rdata_o = {{PAD_W{1'b0}}, mask};
      A_EN:    reg_rdata_o = {{(DATA_W-1){1'b0}}, en};
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:STAT_W];

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irq_o);

  // R5
  sum_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum) |-> ($past(evt_i[HI_HI:HI_LO]) != '0));
endmodule

// File: tb/isu_top_tb.sv
module isu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] evt = '0;
  logic [1:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  isu_top u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_addr_i(addr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic bit impl(int i);
    return (i < 15) || (i == 16) || (i >= 20 && i <= 25);
  endfunction

  function automatic logic [31:0] keep(logic [25:0] v);
    logic [31:0] r = '0;
    for (int i = 0; i < 26; i++) r[i] = v[i] & impl(i);
    return r;
  endfunction

  function automatic logic [31:0] viewof(logic [31:0] st);
    return st | ({31'b0, |st[25:16]} << 15);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse(logic [25:0] v);
    @(negedge clk); evt = v;
    @(negedge clk); evt = '0;
    #1;
  endtask

  task automatic rdreg(logic [1:0] a, output logic [31:0] v, input logic [25:0] ev = '0);
    @(negedge clk); addr = a; rd = 1'b1; evt = ev;
    #1 v = rdata;
    @(negedge clk); rd = 1'b0; evt = '0;
    #1;
  endtask

  task automatic wrreg(logic [1:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, acc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rdreg(2'd0, v); check("R1 status", v, 32'h0);
    rdreg(2'd1, v); check("R1 mask", v, 32'h0);
    rdreg(2'd2, v); check("R1 enable", v, 32'h0);

    // R2 R5 R6 R8: every event position, enabled but fully masked
    wrreg(2'd2, 32'h1);
    for (int i = 0; i < 26; i++) begin
      pulse(26'(1) << i);
      check("R6 masked irq low", {31'b0, irq}, 32'h0);
      rdreg(2'd0, v);
      check("R2 R5 R8 status", v, viewof(keep(26'(1) << i)));
      rdreg(2'd0, v);
      check("R3 cleared", v, 32'h0);
    end

    // R7: open one mask bit at a time
    for (int i = 0; i < 26; i++) begin
      wrreg(2'd1, 32'(1) << i);
      pulse(26'(1) << i);
      check("R7 irq single", {31'b0, irq}, {31'b0, impl(i) && i != 15});
      rdreg(2'd0, v);
      check("R7 irq after clear", {31'b0, irq}, 32'h0);
    end
    // R7 summary gate via mask bit 15
    wrreg(2'd1, 32'h0000_8000);
    pulse(26'(1) << 22);
    check("R7 summary irq", {31'b0, irq}, 32'h1);
    wrreg(2'd2, 32'h0);
    check("R7 enable off", {31'b0, irq}, 32'h0);
    wrreg(2'd2, 32'h1);
    check("R7 enable on", {31'b0, irq}, 32'h1);
    rdreg(2'd0, v);
    check("R5 summary read", v, 32'h0040_8000);

    // R4 event coinciding with a read
    pulse(26'h8);
    rdreg(2'd0, v, 26'h2);
    check("R4 read excludes coincident", v, 32'h8);
    rdreg(2'd0, v);
    check("R4 coincident kept", v, 32'h2);

    // R9 status write ignored
    pulse(26'h40);
    wrreg(2'd0, 32'hFFFF_FFFF);
    rdreg(2'd0, v);
    check("R9 status write ignored", v, 32'h40);

    // R10 R11 R12 readback
    wrreg(2'd1, 32'hFFFF_FFFF);
    rdreg(2'd1, v); check("R10 mask readback", v, 32'h03FF_FFFF);
    wrreg(2'd2, 32'hFFFF_FFFE);
    rdreg(2'd2, v); check("R11 enable bit0 only", v, 32'h0);
    wrreg(2'd2, 32'hFFFF_FFFF);
    rdreg(2'd2, v); check("R11 enable readback", v, 32'h1);
    pulse(26'h3FF_FFFF);
    rdreg(2'd3, v); check("R12 addr3 zero", v, 32'h0);
    rdreg(2'd1, v); check("R10 mask read keeps status", {31'b0, irq}, 32'h1);

    // R2 R8 accumulation of several patterns without a read
    rdreg(2'd0, v);
    for (int k = 1; k < 9; k++) begin
      acc = '0;
      for (int j = 0; j < 3; j++) begin
        logic [25:0] p = 26'((k * 32'h0135_79BD + j * 32'h00AB_CDEF) ^ (32'h1 << (k + j)));
        acc |= keep(p);
        pulse(p);
      end
      rdreg(2'd0, v);
      check("R2 R8 accumulate", v, viewof(acc));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule